// File: doc/BRIEF.md
# User-Bit to CD Subcode Converter

This block sits behind a digital audio receiver's frame decoder. It turns the recovered user-bit stream into a CD-style serial subcode port. Each user bit arrives with a one-cycle strobe. The converter has three jobs:

- It watches for long runs of zero bits, which mark the start of a subcode block.
- It locks its frame timing to the start bits embedded in the stream.
- It gathers the seven Q..W data bits that follow each start bit into one symbol.

When a symbol is complete, the converter prefixes a P bit. The P bit is high for the first two symbols of every block and low otherwise. The resulting eight-bit word is loaded into an output shift register. An external host then clocks the word out on its own bit clock.

The frame sync output rises when a start bit is recognised and falls when the symbol it opens is complete. Its edges therefore follow the spacing of the incoming start bits, not a local timer. The block sync output is a single-cycle pulse. While the lock-error input is high, every output is held low and all internal state is cleared.

Top module: `ubit_subcode_conv`

## Requirements
- R1: While `lock_err` is high, all state is cleared. From the cycle after `lock_err` is sampled high, `blk_sync`, `frm_sync` and `sub_data` are low. After `lock_err` is released, P reads 0 until a new block sync is seen.
- R2: When a zero bit is strobed and it is the 22nd consecutive zero user bit, `blk_sync` is high for exactly the following cycle. Further zeros in the same run do not pulse it again.
- R3: A strobed one bit restarts the zero-run count. A run of 21 zeros followed by a one produces no block sync pulse.
- R4: While no symbol is being gathered, a strobed one is a start bit. `frm_sync` is high from the cycle after that strobe.
- R5: While no symbol is being gathered, a strobed zero is sync fill. It leaves `frm_sync` low and starts no symbol.
- R6: The seven strobes after a start bit are the symbol's data bits. The cycle after the seventh, `frm_sync` returns low and the word is loaded into the output shift register, replacing any earlier contents.
- R7: After a load, `sub_data` presents the word bits in this order: P, then the data bits in arrival order (first data bit = Q, last = W). The presented bit advances by one on each falling edge of `sub_clk`, after a two-flop synchronizer. After all eight bits have been shifted past, `sub_data` reads 0.
- R8: The P bit is 1 in the first two words loaded after a block sync pulse and 0 in every later word. It is also 0 in any word loaded before the first block sync after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_err | input | 1 | Receiver lock error; clears the converter and mutes its outputs |
| ubit_valid | input | 1 | One-cycle strobe qualifying `ubit` |
| ubit | input | 1 | Recovered user bit |
| sub_clk | input | 1 | Host subcode bit clock; data advances on its falling edge |
| blk_sync | output | 1 | One-cycle block sync pulse |
| frm_sync | output | 1 | Frame sync, high while a symbol is being gathered |
| sub_data | output | 1 | Serial subcode data, P first |

## Verification
The assertions assume that `ubit_valid` is a pulse in the core clock domain, and that a new strobe never coincides with the cycle in which `lock_err` is released. The stimulus spaces every strobe by at least one idle cycle. It changes `lock_err` only between bits.

The assertions also assume that `sub_clk` stays level for several core cycles. The stimulus holds each `sub_clk` level for at least four core cycles. It never toggles `sub_clk` while a symbol is being loaded, so the case where a load and a shift edge arrive together is not exercised.

// File: rtl/ubsc_pkg.sv
package ubsc_pkg;
    typedef enum logic {
        ASM_HUNT    = 1'b0,
        ASM_COLLECT = 1'b1
    } asm_state_e;
endpackage

// File: rtl/ubsc_zero_run.sv
module ubsc_zero_run #(
    parameter int SYNC_RUN = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_valid,
    input  logic bit_val,
    output logic hit_o,
    output logic blk_o
);
    localparam int CW = $clog2(SYNC_RUN + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(SYNC_RUN - 1);
    localparam logic [CW-1:0] RUN_MAX  = CW'(SYNC_RUN);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          pulse;
    } zr_t;

    zr_t zr_d, zr_q;

    always_comb begin
        zr_d       = zr_q;
        zr_d.pulse = 1'b0;
        if (clear) begin
            zr_d = '0;
        end else if (bit_valid) begin
            if (bit_val) begin
                zr_d.run = '0;
            end else begin
                if (zr_q.run == RUN_LAST) zr_d.pulse = 1'b1;
                if (zr_q.run != RUN_MAX)  zr_d.run = zr_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zr_q <= '0;
        else        zr_q <= zr_d;
    end

    assign hit_o = zr_d.pulse;
    assign blk_o = zr_q.pulse;
endmodule

// File: rtl/ubsc_symbol_asm.sv
module ubsc_symbol_asm
    import ubsc_pkg::*;
#(
    parameter int DATA_BITS = 7,
    parameter int P_FRAMES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 bit_valid,
    input  logic                 bit_val,
    input  logic                 blk_hit,
    output logic                 frm_o,
    output logic                 load_o,
    output logic [DATA_BITS:0]   word_o
);
    localparam int BW = $clog2(DATA_BITS + 1);
    localparam int FW = $clog2(P_FRAMES + 1);
    localparam logic [BW-1:0] LAST_BIT   = BW'(DATA_BITS - 1);
    localparam logic [FW-1:0] FRAMES_SAT = FW'(P_FRAMES);

    typedef struct packed {
        asm_state_e           st;
        logic [BW-1:0]        cnt;
        logic [DATA_BITS-1:0] sym;
        logic [FW-1:0]        frames;
        logic                 frm;
    } asm_t;

    localparam asm_t ASM_RST = '{st: ASM_HUNT, cnt: '0, sym: '0,
                                 frames: FRAMES_SAT, frm: 1'b0};

    asm_t asm_d, asm_q;
    logic load_d;

    always_comb begin
        asm_d  = asm_q;
        load_d = 1'b0;
        if (clear) begin
            asm_d = ASM_RST;
        end else begin
            if (blk_hit) asm_d.frames = '0;
            if (bit_valid) begin
                case (asm_q.st)
                    ASM_HUNT: begin
                        if (bit_val) begin
                            asm_d.st  = ASM_COLLECT;
                            asm_d.cnt = '0;
                            asm_d.sym = '0;
                            asm_d.frm = 1'b1;
                        end
                    end
                    default: begin
                        asm_d.sym = {asm_q.sym[DATA_BITS-2:0], bit_val};
                        if (asm_q.cnt == LAST_BIT) begin
                            load_d    = 1'b1;
                            asm_d.frm = 1'b0;
                            asm_d.st  = ASM_HUNT;
                            if (asm_q.frames != FRAMES_SAT)
                                asm_d.frames = asm_q.frames + 1'b1;
                        end else begin
                            asm_d.cnt = asm_q.cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) asm_q <= ASM_RST;
        else        asm_q <= asm_d;
    end

    assign frm_o  = asm_q.frm;
    assign load_o = load_d;
    assign word_o = {(asm_q.frames < FRAMES_SAT), asm_d.sym};
endmodule

// File: rtl/ubsc_shifter.sv
module ubsc_shifter #(
    parameter int WORD_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] word,
    input  logic                 host_clk,
    output logic                 sdata_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [WORD_BITS-1:0]   sh;
    } sh_t;

    sh_t sh_d, sh_q;
    logic fall;

    always_comb begin
        sh_d      = sh_q;
        sh_d.sync = {sh_q.sync[SYNC_STAGES-2:0], host_clk};
        sh_d.prev = sh_q.sync[SYNC_STAGES-1];
        fall      = sh_q.prev & ~sh_q.sync[SYNC_STAGES-1];
        if (clear) begin
            sh_d.sh = '0;
        end else if (load) begin
            sh_d.sh = word;
        end else if (fall) begin
            sh_d.sh = {sh_q.sh[WORD_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdata_o = sh_q.sh[WORD_BITS-1];
endmodule

// File: rtl/ubit_subcode_conv.sv
module ubit_subcode_conv #(
    parameter int SYNC_RUN    = 22,
    parameter int DATA_BITS   = 7,
    parameter int P_FRAMES    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_err,
    input  logic ubit_valid,
    input  logic ubit,
    input  logic sub_clk,
    output logic blk_sync,
    output logic frm_sync,
    output logic sub_data
);
    localparam int WORD_BITS = DATA_BITS + 1;

    logic                 blk_hit;
    logic                 sym_load;
    logic [WORD_BITS-1:0] sym_word;

    ubsc_zero_run #(.SYNC_RUN(SYNC_RUN)) u_zero_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (lock_err),
        .bit_valid (ubit_valid),
        .bit_val   (ubit),
        .hit_o     (blk_hit),
        .blk_o     (blk_sync)
    );

    ubsc_symbol_asm #(.DATA_BITS(DATA_BITS), .P_FRAMES(P_FRAMES)) u_symbol_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (lock_err),
        .bit_valid (ubit_valid),
        .bit_val   (ubit),
        .blk_hit   (blk_hit),
        .frm_o     (frm_sync),
        .load_o    (sym_load),
        .word_o    (sym_word)
    );

    ubsc_shifter #(.WORD_BITS(WORD_BITS), .SYNC_STAGES(SYNC_STAGES)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (lock_err),
        .load     (sym_load),
        .word     (sym_word),
        .host_clk (sub_clk),
        .sdata_o  (sub_data)
    );
endmodule

// File: rtl/ubit_subcode_conv_chk.sv
module ubit_subcode_conv_chk (
    input logic clk,
    input logic rst_n,
    input logic lock_err,
    input logic ubit_valid,
    input logic ubit,
    input logic blk_sync,
    input logic frm_sync,
    input logic sub_data
);
    AST_LOCK_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> (!blk_sync && !frm_sync && !sub_data)); // R1

    AST_BLK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_sync |=> !blk_sync); // R2

    AST_BLK_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        blk_sync |-> $past(ubit_valid && !ubit && !lock_err)); // R3

    AST_FRM_RISE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_sync) |-> $past(ubit_valid && ubit)); // R4

    AST_FRM_FALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_sync) |-> $past(ubit_valid || lock_err)); // R6
endmodule

bind ubit_subcode_conv ubit_subcode_conv_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_err   (lock_err),
    .ubit_valid (ubit_valid),
    .ubit       (ubit),
    .blk_sync   (blk_sync),
    .frm_sync   (frm_sync),
    .sub_data   (sub_data)
);

// File: tb/test_ubit_subcode_conv.sv
module test_ubit_subcode_conv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_err = 1'b0;
    logic ubit_valid = 1'b0;
    logic ubit = 1'b0;
    logic sub_clk = 1'b1;
    logic blk_sync, frm_sync, sub_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench reference state
    int       m_run = 0;
    bit       m_collect = 1'b0;
    int       m_cnt = 0;
    bit [6:0] m_sym = '0;
    int       m_frames = 2;
    bit       m_frm = 1'b0;
    bit [7:0] m_word = '0;

    always #2.5 clk = ~clk;

    ubit_subcode_conv i_ubit_subcode_conv (
        .clk(clk), .rst_n(rst_n), .lock_err(lock_err),
        .ubit_valid(ubit_valid), .ubit(ubit), .sub_clk(sub_clk),
        .blk_sync(blk_sync), .frm_sync(frm_sync), .sub_data(sub_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit p_of(input int frames);
        return frames < 2;
    endfunction

    task automatic model_reset();
        m_run = 0; m_collect = 0; m_cnt = 0; m_sym = '0; m_frames = 2; m_frm = 0;
    endtask

    // returns 1 when the strobe completes a word
    task automatic send_bit(input bit b, output bit loaded);
        bit exp_blk;
        loaded  = 1'b0;
        exp_blk = (!b && m_run == 21);
        if (b) m_run = 0; else m_run++;
        if (exp_blk) m_frames = 0;
        if (!m_collect) begin
            if (b) begin m_collect = 1; m_cnt = 0; m_sym = '0; m_frm = 1; end
        end else begin
            m_sym = {m_sym[5:0], b};
            if (m_cnt == 6) begin
                m_word = {p_of(m_frames), m_sym};
                if (m_frames < 2) m_frames++;
                m_collect = 0; m_frm = 0; loaded = 1'b1;
            end else m_cnt++;
        end
        @(negedge clk); ubit_valid = 1'b1; ubit = b;
        @(negedge clk); ubit_valid = 1'b0;
        chk(blk_sync == exp_blk, exp_blk ? "R2 block sync pulse" : "R3 no block sync",
            int'(blk_sync), int'(exp_blk));
        chk(frm_sync == m_frm, m_collect ? "R4 frame sync" : "R5/R6 frame sync",
            int'(frm_sync), int'(m_frm));
        @(negedge clk);
        if (exp_blk) chk(blk_sync == 1'b0, "R2 pulse one cycle", int'(blk_sync), 0);
    endtask

    task automatic read_word(input bit [7:0] w);
        chk(sub_data == w[7], "R8 P bit first", int'(sub_data), int'(w[7]));
        for (int i = 6; i >= 0; i--) begin
            sub_clk = 1'b0;
            repeat (6) @(negedge clk);
            chk(sub_data == w[i], "R7 serial order", int'(sub_data), int'(w[i]));
            sub_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sub_clk = 1'b0;
        repeat (6) @(negedge clk);
        chk(sub_data == 1'b0, "R7 zero after word", int'(sub_data), 0);
        sub_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_symbol(input bit [6:0] d);
        bit ld;
        send_bit(1'b1, ld);
        for (int i = 6; i >= 0; i--) send_bit(d[i], ld);
        chk(ld == 1'b1, "R6 word loaded", int'(ld), 1);
        read_word(m_word);
    endtask

    task automatic send_zeros(input int n);
        bit ld;
        for (int i = 0; i < n; i++) send_bit(1'b0, ld);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(blk_sync == 0 && frm_sync == 0 && sub_data == 0, "R1 reset state",
            int'({blk_sync, frm_sync, sub_data}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // symbol before any block sync: P = 0 (R8)
        send_zeros(3);
        send_symbol(7'b1010011);
        // 21 zeros then a one: no block sync (R3)
        send_zeros(21);
        send_symbol(7'b0000001);
        // exact block sync run and first frames (R2, R8)
        send_zeros(22);
        send_symbol(7'b1111111);
        send_symbol(7'b0110101);
        send_symbol(7'b1000000);
        // long run only pulses once (R2)
        send_zeros(30);
        send_symbol(7'b0101010);

        // lock error mid-symbol clears everything (R1)
        begin
            bit ld;
            send_bit(1'b1, ld);
            send_bit(1'b1, ld);
            @(negedge clk); lock_err = 1'b1;
            @(negedge clk);
            chk(frm_sync == 0 && blk_sync == 0 && sub_data == 0, "R1 lock mutes",
                int'({blk_sync, frm_sync, sub_data}), 0);
            @(negedge clk); lock_err = 1'b0;
            @(negedge clk);
            model_reset();
            send_symbol(7'b1111111); // P must be 0 after lock (R1)
        end

        // constrained random stream
        for (int s = 0; s < 60; s++) begin
            if (s % 12 == 0) send_zeros(22 + int'($urandom_range(0, 4)));
            else send_zeros(int'($urandom_range(0, 4)));
            send_symbol(7'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule